// File: doc/BRIEF.md
# Hermitian-Symmetric 16-QAM Subcarrier Mapper

This block sits in front of an IFFT in an intensity-modulated optical OFDM transmitter. It accepts bytes from a processor-side stream and splits each byte into two 4-bit groups. The groups are buffered until one frame's worth is present. Each group is then converted to a 16-QAM point through a constant table, and the points are written into a subcarrier memory. The frame is emitted one frequency bin at a time. The lower half of the frame carries the data points. The upper half is produced on the fly as the complex conjugate of the mirrored lower bin, so the inverse transform of every frame is real-valued.

With the default size of 64 bins, bins 1 to 31 carry data, so one frame holds 31 groups (124 bits). Bytes do not divide evenly into frames. When a frame fills with the first group of a byte, the second group of that byte opens the next frame. An input byte flagged as final ends the packet: the rest of the frame that holds its last group is filled with zero-valued groups. The input stream is held off while a frame is being mapped or emitted.

Top module: `hsym_qam_mapper`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Each byte yields two groups, bits [3:0] first and then bits [7:4]. The j-th group of the stream is placed in bin (j mod 31)+1 of frame floor(j/31).
- R3: A group g maps to the real part from g[1:0] and the imaginary part from g[3:2]. Each 2-bit pair is Gray-coded as 00→-3, 01→-1, 11→+1, 10→+3, and the level is multiplied by the parameter LEVEL (default 8192) in signed 16-bit form. Every emitted real part is 0, ±LEVEL or ±3·LEVEL.
- R4: Bin 0 and bin N/2 are emitted as zero in both parts.
- R5: For 0 < k < N/2, bin N−k is emitted with the real part of bin k and the negated imaginary part of bin k.
- R6: A frame is N consecutive bins in index order. `out_last` is high on bin N−1 only, and `out_valid` is low in the cycle after that bin is accepted.
- R7: After a byte accepted with `in_last`, the remaining groups of the frame holding its last group are zero. A zero group maps to (−3·LEVEL, −3·LEVEL).
- R8: A group that does not fit in the current frame begins the next frame, and no group is lost or repeated.
- R9: `in_ready` stays low whenever `out_valid` is high. It also stays low from the moment a frame fills until the last bin of that frame is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_re`, `out_im` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_last | input | 1 | Byte is the final one of a packet |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_re | output | 16 | Real part of the current bin |
| out_im | output | 16 | Imaginary part of the current bin |
| out_valid | output | 1 | Bin present |
| out_last | output | 1 | Bin is N−1 |
| out_ready | input | 1 | Downstream accepts the bin |

## Verification
The hardest case to reach is a group that crosses a frame boundary while a packet end is pending. In that case the second group of the final byte must open a new frame and be followed by 30 zero groups. The stimulus reaches it by sending a 16-byte packet with its final flag. The 31st group then fills the first frame, and the 32nd group, from the final byte, spills into the second frame. An unflagged 31-byte stream checks the plain boundary carry. A throttled `out_ready` pattern exercises holding the output and stalling the input.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

  typedef enum logic [1:0] {
    ST_FILL,
    ST_MAP,
    ST_EMIT
  } hsq_state_e;

  // Gray-coded amplitude for one axis: 00->-3, 01->-1, 11->+1, 10->+3
  function automatic logic signed [2:0] gray_lvl(input logic [1:0] b);
    case (b)
      2'b00:   gray_lvl = -3'sd3;
      2'b01:   gray_lvl = -3'sd1;
      2'b11:   gray_lvl = 3'sd1;
      default: gray_lvl = 3'sd3;
    endcase
  endfunction

endpackage

// File: rtl/hsq_sdp_ram.sv
module hsq_sdp_ram #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hsq_qam16_lut.sv
module hsq_qam16_lut
  import hsq_pkg::*;
#(
  parameter int SW    = 16,
  parameter int LEVEL = 8192
) (
  input  logic [3:0]           grp,
  output logic signed [SW-1:0] re,
  output logic signed [SW-1:0] im
);
  logic signed [SW-1:0] axis_v [2];

  for (genvar g = 0; g < 2; g++) begin : g_axis
    always_comb axis_v[g] = SW'(int'(gray_lvl(grp[2*g+1 -: 2])) * LEVEL);
  end

  assign re = axis_v[0];
  assign im = axis_v[1];
endmodule

// File: rtl/hsym_qam_mapper.sv
module hsym_qam_mapper
  import hsq_pkg::*;
#(
  parameter int NFFT  = 64,
  parameter int SW    = 16,
  parameter int LEVEL = 8192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           in_data,
  input  logic                 in_valid,
  input  logic                 in_last,
  output logic                 in_ready,
  output logic signed [SW-1:0] out_re,
  output logic signed [SW-1:0] out_im,
  output logic                 out_valid,
  output logic                 out_last,
  input  logic                 out_ready
);
  localparam int HALF  = NFFT / 2;
  localparam int DBINS = HALF - 1;
  localparam int CW    = $clog2(DBINS + 1);
  localparam int NB_AW = $clog2(DBINS);
  localparam int SC_AW = $clog2(HALF);
  localparam int IBW   = $clog2(NFFT) + 1;

  hsq_state_e st;

  // fill stage
  logic [CW-1:0] cnt;
  logic          hold_v, pad;
  logic [3:0]    hold_grp;
  logic          full;
  logic          nb_we;
  logic [3:0]    nb_wdata, nb_rdata;

  assign full     = (cnt == CW'(DBINS));
  assign in_ready = (st == ST_FILL) && !full && !hold_v && !pad;

  always_comb begin
    nb_we    = 1'b0;
    nb_wdata = 4'd0;
    if (st == ST_FILL && !full) begin
      if (hold_v) begin
        nb_we    = 1'b1;
        nb_wdata = hold_grp;
      end else if (pad) begin
        nb_we    = 1'b1;
      end else if (in_valid) begin
        nb_we    = 1'b1;
        nb_wdata = in_data[3:0];
      end
    end
  end

  // map stage
  logic [CW-1:0]          mc;
  logic                   nb_re, mv;
  logic [SC_AW-1:0]       ma;
  logic signed [SW-1:0]   lut_re, lut_im;

  assign nb_re = (st == ST_MAP) && (mc != CW'(DBINS));

  hsq_sdp_ram #(.W(4), .AW(NB_AW)) u_grp_buf (
    .clk(clk), .we(nb_we), .waddr(cnt[NB_AW-1:0]), .wdata(nb_wdata),
    .re(nb_re), .raddr(mc[NB_AW-1:0]), .rdata(nb_rdata)
  );

  hsq_qam16_lut #(.SW(SW), .LEVEL(LEVEL)) u_lut (
    .grp(nb_rdata), .re(lut_re), .im(lut_im)
  );

  // emit stage
  logic [IBW-1:0]   ib, pb, mirror;
  logic             pend, issue, fire;
  logic [SC_AW-1:0] sc_raddr;
  logic [2*SW-1:0]  sc_rdata;
  logic signed [SW-1:0] rd_re, rd_im;

  assign fire     = out_valid && out_ready;
  assign issue    = (st == ST_EMIT) && (ib < IBW'(NFFT)) && !pend && (!out_valid || out_ready);
  assign mirror   = IBW'(NFFT) - ib;
  assign sc_raddr = (ib < IBW'(HALF)) ? ib[SC_AW-1:0] : mirror[SC_AW-1:0];
  assign rd_re    = sc_rdata[2*SW-1:SW];
  assign rd_im    = sc_rdata[SW-1:0];

  hsq_sdp_ram #(.W(2*SW), .AW(SC_AW)) u_subcar (
    .clk(clk), .we(mv), .waddr(ma), .wdata({lut_re, lut_im}),
    .re(issue), .raddr(sc_raddr), .rdata(sc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FILL;
      cnt       <= '0;
      hold_v    <= 1'b0;
      hold_grp  <= 4'd0;
      pad       <= 1'b0;
      mc        <= '0;
      mv        <= 1'b0;
      ma        <= '0;
      ib        <= '0;
      pb        <= '0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      mv   <= nb_re;
      ma   <= mc[SC_AW-1:0] + SC_AW'(1);
      pend <= issue;
      if (issue) begin
        pb <= ib;
        ib <= ib + IBW'(1);
      end

      case (st)
        ST_FILL: begin
          if (full) begin
            if (!hold_v) pad <= 1'b0;
            cnt <= '0;
            mc  <= '0;
            st  <= ST_MAP;
          end else if (hold_v) begin
            hold_v <= 1'b0;
            cnt    <= cnt + CW'(1);
          end else if (pad) begin
            cnt <= cnt + CW'(1);
          end else if (in_valid) begin
            cnt      <= cnt + CW'(1);
            hold_grp <= in_data[7:4];
            hold_v   <= 1'b1;
            pad      <= in_last;
          end
        end
        ST_MAP: begin
          if (mc == CW'(DBINS)) begin
            ib <= '0;
            st <= ST_EMIT;
          end else begin
            mc <= mc + CW'(1);
          end
        end
        default: begin
          if (fire && out_last) st <= ST_FILL;
        end
      endcase

      if (pend) begin
        out_valid <= 1'b1;
        out_last  <= (pb == IBW'(NFFT - 1));
        if (pb == '0 || pb == IBW'(HALF)) begin
          out_re <= '0;
          out_im <= '0;
        end else begin
          out_re <= rd_re;
          out_im <= (pb > IBW'(HALF)) ? -rd_im : rd_im;
        end
      end else if (fire) begin
        out_valid <= 1'b0;
      end
    end
  end

  function automatic logic level_ok(input logic signed [SW-1:0] v);
    level_ok = (v == 0) || (v == SW'(LEVEL)) || (v == -SW'(LEVEL)) ||
               (v == SW'(3 * LEVEL)) || (v == -SW'(3 * LEVEL));
  endfunction

  AST_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)); // R10

  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> level_ok(out_re) && level_ok(out_im)); // R3

  AST_LAST_GAP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid); // R6

endmodule

// File: tb/tb_hsym_qam_mapper.sv
module tb_hsym_qam_mapper;
  localparam int NFFT  = 64;
  localparam int HALF  = NFFT / 2;
  localparam int DBINS = HALF - 1;
  localparam int LEVEL = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_data = 8'd0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic signed [15:0] out_re, out_im;
  logic out_valid, out_last;
  logic out_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  int exp_grp [0:255];
  logic signed [15:0] g_re [0:511];
  logic signed [15:0] g_im [0:511];
  logic               g_last [0:511];

  always #5 clk = ~clk;

  hsym_qam_mapper #(.NFFT(NFFT), .SW(16), .LEVEL(LEVEL)) dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .out_re(out_re), .out_im(out_im), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready)
  );

  function automatic int lvl(input int b);
    case (b & 3)
      0: lvl = -3 * LEVEL;
      1: lvl = -1 * LEVEL;
      3: lvl = LEVEL;
      default: lvl = 3 * LEVEL;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  // Sends nbytes, collects frames, checks every bin against the model
  task automatic t_stream(input int nbytes, input int seed, input bit use_last,
                          input int rmode, input string tag);
    int ngrp, nfr, total, got, stall_bad, hold_bad, cyc;
    bit prev_stall;
    logic signed [15:0] p_re, p_im;
    logic p_last;
    ngrp = 2 * nbytes;
    for (int i = 0; i < nbytes; i++) begin
      int b;
      b = (i * 37 + seed) & 255;
      exp_grp[2*i]   = b & 15;
      exp_grp[2*i+1] = (b >> 4) & 15;
    end
    if (use_last) while (ngrp % DBINS != 0) begin
      exp_grp[ngrp] = 0;
      ngrp++;
    end
    nfr = ngrp / DBINS;
    total = nfr * NFFT;
    got = 0; stall_bad = 0; hold_bad = 0; cyc = 0; prev_stall = 1'b0;
    p_re = '0; p_im = '0; p_last = 1'b0;
    fork
      begin
        for (int i = 0; i < nbytes; ) begin
          bit acc;
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = 8'((i * 37 + seed) & 255);
          in_last  = use_last && (i == nbytes - 1);
          acc = in_ready;
          @(posedge clk);
          if (acc) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      begin
        while (got < total && cyc < 20000) begin
          bit rdy;
          @(negedge clk);
          cyc++;
          if (prev_stall && (out_re !== p_re || out_im !== p_im || out_last !== p_last || !out_valid))
            hold_bad++;
          rdy = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
          out_ready = rdy;
          if (out_valid && in_ready) stall_bad++;
          if (out_valid && rdy) begin
            g_re[got] = out_re; g_im[got] = out_im; g_last[got] = out_last;
            got++;
          end
          prev_stall = out_valid && !rdy;
          p_re = out_re; p_im = out_im; p_last = out_last;
        end
      end
    join
    check(got == total, tag, "bins collected", got, total);
    for (int f = 0; f < nfr; f++) begin
      for (int k = 0; k < NFFT; k++) begin
        int er, ei, idx, m;
        idx = f * NFFT + k;
        if (k == 0 || k == HALF) begin
          er = 0; ei = 0;
        end else begin
          m  = (k < HALF) ? k : NFFT - k;
          er = lvl(exp_grp[f * DBINS + m - 1]);
          ei = lvl(exp_grp[f * DBINS + m - 1] >> 2);
          if (k > HALF) ei = -ei;
        end
        if (k == 0 || k == HALF) begin
          check(g_re[idx] == er && g_im[idx] == ei, {tag, " R4"}, "zero bin re", int'(g_re[idx]), er);
        end else if (k < HALF) begin
          check(g_re[idx] == er, {tag, " R2 R3"}, "data bin re", int'(g_re[idx]), er);
          check(g_im[idx] == ei, {tag, " R2 R3"}, "data bin im", int'(g_im[idx]), ei);
        end else begin
          check(g_re[idx] == er && g_im[idx] == ei, {tag, " R5"}, "mirror bin im", int'(g_im[idx]), ei);
        end
        check(g_last[idx] == (k == NFFT - 1), "R6", "last flag", int'(g_last[idx]), int'(k == NFFT - 1));
      end
    end
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R6", "no extra bins", int'(out_valid), 0);
    check(stall_bad == 0, "R9", "input ready while emitting", stall_bad, 0);
    check(hold_bad == 0, "R10", "output changed while stalled", hold_bad, 0);
    check(in_ready == 1'b1, "R9", "input reopens after frame", int'(in_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    // two full frames, group 31 spills into frame 2: R8
    t_stream(31, 5, 1'b0, 0, "R8");
    // short packet, padded to a full frame, throttled output: R7 R10
    t_stream(5, 200, 1'b1, 1, "R7");
    // boundary crossing on the final byte: R7 and R8 together
    t_stream(16, 91, 1'b1, 1, "R7 R8");
    // longer packet with continuous ready
    t_stream(40, 13, 1'b1, 0, "R2");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule